// File: doc/BRIEF.md
# Per-Set FIFO Victim Order Queue

This block keeps the replacement order for a set-associative cache that evicts on a first-in, first-out basis. Every set owns a small circular queue of way indices. Whenever the cache fills a way, whether the way was empty before or has just been evicted, it pushes that way index onto the queue of the set. When the cache needs a victim in a full set, it pops the queue of that set and gets back the way that was filled longest ago. Cache hits issue no strobe, so they never change the order. Tag lookup and data storage belong to the surrounding cache.

Both sides use a valid/ready handshake. A transfer happens on a rising clock edge when valid and ready are both high. Until then the requester holds valid, the set index and the way index steady. `pop_ready` is high exactly when the addressed set holds at least one entry. While `pop_ready` is high, `pop_way` shows the oldest way of `pop_set` in the same cycle. `push_ready` is high when the addressed set has room. It is also high when a pop of that same set is completing in the same cycle. Neither ready signal depends on its own valid.

Top module: `way_fifo_repl`

## Requirements
- R1: After reset every set queue is empty: `pop_ready` is 0 and `push_ready` is 1 for every set index.
- R2: An accepted push of way W into set S appends W as the newest entry of S.
- R3: While `pop_valid` and `pop_ready` are high, `pop_way` equals the oldest entry of `pop_set`, and the handshake removes that entry.
- R4: `pop_ready` is 1 exactly when the queue of `pop_set` is non-empty. A pop request to an empty set is not accepted and changes nothing.
- R5: Each set keeps its own queue: pushes and pops addressed to one set never change the contents or order of another set.
- R6: A push and a pop of the same set in the same cycle are both accepted, even when the set is full. The popped way is the oldest entry from before the push, and the occupancy stays the same.
- R7: A set holds at most WAYS entries. A push to a full set with no same-set pop in that cycle sees `push_ready` 0 and leaves the queue unchanged.
- R8: Cycles with no accepted push or pop (cache hits) leave every queue's order unchanged.
- R9: A victim way that is popped and then pushed again becomes the newest entry of its set and is returned again only after all older entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Fill request valid |
| push_ready | output | 1 | Target set can accept the fill |
| push_set | input | clog2(NUM_SETS) | Set index of the fill |
| push_way | input | clog2(WAYS) | Way index that was filled |
| pop_valid | input | 1 | Victim request valid |
| pop_ready | output | 1 | Target set has an entry to give |
| pop_set | input | clog2(NUM_SETS) | Set index of the victim request |
| pop_way | output | clog2(WAYS) | Oldest way of `pop_set` |

## Verification
A wrong head pointer or slot write in this block shows up as a wrong `pop_way` on the very next pop of the affected set. That can be many cycles after the fault, so the reference model compares every accepted pop. A wrong occupancy count shows up within one cycle as a wrong `pop_ready` or `push_ready` for that set. The bench checks both ready signals on every cycle, including full sets that also see a same-set pop. Fills are limited to a few sets during the random phase so that queues wrap and fill often.

// File: rtl/wfq_pkg.sv
package wfq_pkg;
  // Index width with a floor of one bit so that single-entry shapes still elaborate.
  function automatic int idx_width(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/wfq_set_queue.sv
module wfq_set_queue
  import wfq_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [WAY_W-1:0] push_way,
  input  logic             pop_en,
  output logic [WAY_W-1:0] head_way,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = idx_width(WAYS);
  localparam int CNT_W = $clog2(WAYS + 1);
  localparam int SUM_W = PTR_W + 1;

  logic [WAY_W-1:0] slot_q [WAYS];
  logic [PTR_W-1:0] head_q;
  logic [CNT_W-1:0] count_q;
  logic [SUM_W-1:0] tail_sum;
  logic [PTR_W-1:0] tail_idx;
  logic [PTR_W-1:0] head_nxt;

  always_comb begin
    tail_sum = {1'b0, head_q} + SUM_W'(count_q);
    if (tail_sum >= SUM_W'(WAYS)) tail_idx = PTR_W'(tail_sum - SUM_W'(WAYS));
    else                          tail_idx = PTR_W'(tail_sum);
    head_nxt = (head_q == PTR_W'(WAYS - 1)) ? '0 : head_q + 1'b1;
  end

  // Slot storage. On a full set with a same-cycle pop, the tail index
  // equals the head index, so the write lands on the slot being freed.
  always_ff @(posedge clk) begin
    if (push_en) slot_q[tail_idx] <= push_way;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      count_q <= '0;
    end else begin
      if (pop_en) head_q <= head_nxt;
      case ({push_en, pop_en})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_way = slot_q[head_q];
  assign empty    = (count_q == '0);
  assign full     = (count_q == CNT_W'(WAYS));

  assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(WAYS));
  assert_no_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> count_q != '0);
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !pop_en) |-> count_q < CNT_W'(WAYS));
  assert_swap_keeps_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && pop_en) |=> $stable(count_q));
  assert_idle_keeps_head_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_en |=> $stable(head_q));
endmodule

// File: rtl/wfq_pick.sv
module wfq_pick #(
  parameter int             N     = 8,
  parameter int             W     = 2,
  parameter int             SEL_W = 3,
  parameter logic [W-1:0]   DFLT  = '0
) (
  input  logic [N*W-1:0]  vec,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]    out
);
  always_comb begin
    out = DFLT;
    for (int i = 0; i < N; i++) begin
      if (sel == SEL_W'(i)) out = vec[i*W +: W];
    end
  end
endmodule

// File: rtl/way_fifo_repl.sv
module way_fifo_repl
  import wfq_pkg::*;
#(
  parameter int NUM_SETS = 8,
  parameter int WAYS     = 4,
  localparam int SET_W   = idx_width(NUM_SETS),
  localparam int WAY_W   = idx_width(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  output logic             push_ready,
  input  logic [SET_W-1:0] push_set,
  input  logic [WAY_W-1:0] push_way,
  input  logic             pop_valid,
  output logic             pop_ready,
  input  logic [SET_W-1:0] pop_set,
  output logic [WAY_W-1:0] pop_way
);
  logic [NUM_SETS*WAY_W-1:0] head_vec;
  logic [NUM_SETS-1:0]       empty_vec;
  logic [NUM_SETS-1:0]       full_vec;
  logic [NUM_SETS-1:0]       push_en;
  logic [NUM_SETS-1:0]       pop_en;
  logic                      pop_empty;
  logic                      push_full;
  logic                      pop_fire;
  logic                      push_fire;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    assign push_en[s] = push_fire && (push_set == SET_W'(s));
    assign pop_en[s]  = pop_fire  && (pop_set  == SET_W'(s));

    wfq_set_queue #(.WAYS(WAYS), .WAY_W(WAY_W)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_en  (push_en[s]),
      .push_way (push_way),
      .pop_en   (pop_en[s]),
      .head_way (head_vec[s*WAY_W +: WAY_W]),
      .empty    (empty_vec[s]),
      .full     (full_vec[s])
    );
  end

  wfq_pick #(.N(NUM_SETS), .W(WAY_W), .SEL_W(SET_W), .DFLT('0)) u_pick_head (
    .vec (head_vec), .sel (pop_set), .out (pop_way)
  );
  wfq_pick #(.N(NUM_SETS), .W(1), .SEL_W(SET_W), .DFLT(1'b1)) u_pick_empty (
    .vec (empty_vec), .sel (pop_set), .out (pop_empty)
  );
  wfq_pick #(.N(NUM_SETS), .W(1), .SEL_W(SET_W), .DFLT(1'b1)) u_pick_full (
    .vec (full_vec), .sel (push_set), .out (push_full)
  );

  assign pop_ready  = !pop_empty;
  assign pop_fire   = pop_valid && pop_ready;
  assign push_ready = !push_full || (pop_fire && (pop_set == push_set));
  assign push_fire  = push_valid && push_ready;

  assert_single_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |-> $countones(pop_en) == 1);
  assert_single_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(push_en) <= 1);
  assert_quiet_sets_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_fire |-> pop_en == '0);
endmodule

// File: tb/way_fifo_repl_bench.sv
`timescale 1ns/1ps
module way_fifo_repl_bench;
  localparam int NS = 8;
  localparam int NW = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_valid = 1'b0;
  logic       push_ready;
  logic [2:0] push_set = '0;
  logic [1:0] push_way = '0;
  logic       pop_valid = 1'b0;
  logic       pop_ready;
  logic [2:0] pop_set = '0;
  logic [1:0] pop_way;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int model [NS][$];

  always #2.5 clk = ~clk;

  way_fifo_repl #(.NUM_SETS(NS), .WAYS(NW)) u_way_fifo_repl (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_ready(push_ready),
    .push_set(push_set), .push_way(push_way),
    .pop_valid(pop_valid), .pop_ready(pop_ready),
    .pop_set(pop_set), .pop_way(pop_way)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One clock of stimulus: drive after the falling edge, check before the
  // rising edge, then advance the reference model at the rising edge.
  task automatic step(input bit pv, input int ps, input int pw,
                      input bit qv, input int qs, input string tag);
    bit exp_pop_rdy, exp_push_rdy, pop_go, push_go;
    @(negedge clk);
    push_valid = pv; push_set = ps[2:0]; push_way = pw[1:0];
    pop_valid  = qv; pop_set  = qs[2:0];
    #1;
    exp_pop_rdy  = model[qs].size() != 0;
    pop_go       = qv && exp_pop_rdy;
    exp_push_rdy = (model[ps].size() < NW) || (pop_go && qs == ps);
    push_go      = pv && exp_push_rdy;
    chk("R4", "pop_ready", int'(pop_ready), int'(exp_pop_rdy));
    chk((model[ps].size() == NW) ? ((pop_go && qs == ps) ? "R6" : "R7") : tag,
        "push_ready", int'(push_ready), int'(exp_push_rdy));
    if (pop_go) chk(tag, "pop_way", int'(pop_way), model[qs][0]);
    @(posedge clk);
    if (pop_go)  void'(model[qs].pop_front());
    if (push_go) model[ps].push_back(pw);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: every set empty after reset
    for (int s = 0; s < NS; s++) begin
      @(negedge clk); pop_set = s[2:0]; push_set = s[2:0]; #1;
      chk("R1", "pop_ready after reset", int'(pop_ready), 0);
      chk("R1", "push_ready after reset", int'(push_ready), 1);
    end
    // R2: fills of invalid ways in set 2, out of way order
    step(1, 2, 3, 0, 0, "R2");
    step(1, 2, 1, 0, 0, "R2");
    step(1, 2, 0, 0, 0, "R2");
    step(1, 2, 2, 0, 0, "R2");
    // R7: full set refuses a lone push
    step(1, 2, 1, 0, 0, "R7");
    // R5: an independent set
    step(1, 5, 0, 0, 0, "R5");
    step(1, 5, 3, 0, 0, "R5");
    // R8: hit cycles with no strobes
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, "R8");
    // R3 then R9: victim 3 is refilled and becomes newest
    step(0, 0, 0, 1, 2, "R3");
    step(1, 2, 3, 0, 0, "R9");
    step(0, 0, 0, 1, 5, "R5");
    step(0, 0, 0, 1, 2, "R3");
    step(0, 0, 0, 1, 2, "R3");
    step(0, 0, 0, 1, 2, "R3");
    step(0, 0, 0, 1, 2, "R9");
    // R4: pop request to an empty set is refused
    step(0, 0, 0, 1, 2, "R4");
    step(0, 0, 0, 1, 5, "R5");
    // R6: swap on a full set
    for (int w = 0; w < NW; w++) step(1, 7, w, 0, 0, "R2");
    step(1, 7, 2, 1, 7, "R6");
    for (int i = 0; i < NW; i++) step(0, 0, 0, 1, 7, "R6");
    // Random traffic concentrated on a few sets
    for (int i = 0; i < 4000; i++)
      step(1'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, NW - 1),
           1'($urandom_range(0, 1)), $urandom_range(0, 3), "R3");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule